// File: doc/BRIEF.md
# Fixed-Priority Interrupt Vector Controller

This block arbitrates among five interrupt sources of a small 8-bit controller core: two external request lines, two timer overflow events and one serial event. The serial event is the OR of a receive flag and a transmit flag. A master enable bit and one enable bit per source gate every request. A priority bit per source places it at the low level or the high level. Inside each level the order is fixed: external 0 first, then timer 0, external 1, timer 1 and serial last.

The controller raises `irq_req` together with the 16-bit entry address of the winning source. The core loads that address into its program counter. When the core pulses `ack`, the controller records which level is now in service and clears the latched flag of that source. A `reti` pulse ends the innermost service. One service may nest inside another, but only a high-level service inside a low-level one. Each external line can be configured as level-sensitive or as rising-edge latched.

The controller has an asynchronous active-low reset. The reset is released synchronously through two flops.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset release, `irq_req`, `act_lo` and `act_hi` are 0, and no source flag is pending.
- R2: A source can be requested only when `glb_en` is 1 and the source's own bit in `src_en` is 1. Clearing `glb_en` withdraws a pending request at once, and no flag is lost.
- R3: Among sources at the same level, the lowest index wins. The index order is 0 = external 0, 1 = timer 0, 2 = external 1, 3 = timer 1, 4 = serial. `irq_src` reports the index of the winner.
- R4: `irq_vec` equals 0x0003 + 8 × index while `irq_req` is 1, which gives 0x0003, 0x000B, 0x0013, 0x001B and 0x0023. It is 0x0000 when no request is raised.
- R5: A source whose `src_hi` bit is 1 wins over every eligible source whose bit is 0, whatever their order.
- R6: With `act_hi` set, no request is raised. With only `act_lo` set, only a high-level source is raised. `ack` while `irq_req` is 1 sets the level of the granted source.
- R7: Only `reti` clears an active level. A `reti` pulse clears `act_hi` if it is set, and otherwise clears `act_lo`.
- R8: A `tmr_ovf` pulse sets the timer flag at the next clock. An accepted `ack` for that timer clears the flag. A new pulse in the same cycle as the `ack` wins, and the flag stays set.
- R9: With `ext_edge_mode` bit 1, a rising edge on `ext_line` latches the flag, and only an accepted `ack` clears it. With the bit at 0, the flag follows the line one clock later, and `ack` does not clear it.
- R10: The serial source is pending while `ser_rx` or `ser_tx` is 1. An `ack` does not clear either flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset |
| ext_line | input | 2 | External request lines, bit k = external k |
| ext_edge_mode | input | 2 | 1 = line k latched on rising edge, 0 = level |
| tmr_ovf | input | 2 | Timer overflow pulses, bit k = timer k |
| ser_rx | input | 1 | Serial receive flag |
| ser_tx | input | 1 | Serial transmit flag |
| glb_en | input | 1 | Master interrupt enable |
| src_en | input | 5 | Per-source enable, indexed as in R3 |
| src_hi | input | 5 | Per-source high-level select, indexed as in R3 |
| ack | input | 1 | Core accepts the presented request |
| reti | input | 1 | Return-from-interrupt pulse |
| irq_req | output | 1 | Request to the core |
| irq_vec | output | 16 | Entry address of the granted source |
| irq_src | output | 3 | Index of the granted source |
| act_lo | output | 1 | Low-level service in progress |
| act_hi | output | 1 | High-level service in progress |

## Verification
The hardest state to reach from the ports is a double nesting: a low-level service, then a high-level service taken on top of it, then unwinding one `reti` at a time. Reaching it needs one source that is still pending after its own `ack`. The stimulus uses the serial source for this, because its flags persist. The bench acknowledges a level-sensitive external source at the low level, then moves the serial source to the high level so that it preempts. Two `reti` pulses then show the levels clearing in order. A separate step pulses the timer in the same cycle as its own `ack`, to show that the new overflow is kept.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  localparam int NPAIR = 2;
  localparam int NSRC  = 2 * NPAIR + 1;
  localparam int SRC_W = $clog2(NSRC);
  localparam int SER_IDX = NSRC - 1;

  function automatic logic [NSRC-1:0] lowest_one(input logic [NSRC-1:0] v);
    return v & (~v + NSRC'(1));
  endfunction
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
  import irq_vec_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPAIR-1:0] ext_line,
  input  logic [NPAIR-1:0] ext_edge,
  input  logic [NPAIR-1:0] tmr_set,
  input  logic [NPAIR-1:0] clr_ext,
  input  logic [NPAIR-1:0] clr_tmr,
  input  logic             ser_rx,
  input  logic             ser_tx,
  output logic [NSRC-1:0]  pend
);

  generate
    for (genvar k = 0; k < NPAIR; k++) begin : g_pair
      logic e_q, e_d, p_q, t_q, t_d;

      // next state: a new set event has priority over a clear
      always_comb begin
        if (ext_edge[k]) begin
          if (ext_line[k] && !p_q)  e_d = 1'b1;
          else if (clr_ext[k])      e_d = 1'b0;
          else                      e_d = e_q;
        end else begin
          e_d = ext_line[k];
        end
        if (tmr_set[k])             t_d = 1'b1;
        else if (clr_tmr[k])        t_d = 1'b0;
        else                        t_d = t_q;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          e_q <= 1'b0;
          p_q <= 1'b0;
          t_q <= 1'b0;
        end else begin
          e_q <= e_d;
          p_q <= ext_line[k];
          t_q <= t_d;
        end
      end

      assign pend[2*k]   = e_q;
      assign pend[2*k+1] = t_q;

      p_tmr_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_set[k] |=> t_q);
      p_edge_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_edge[k] && e_q && !clr_ext[k]) |=> e_q);
    end
  endgenerate

  assign pend[SER_IDX] = ser_rx | ser_tx;

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_vec_pkg::*;
(
  input  logic [NSRC-1:0]  pend,
  input  logic [NSRC-1:0]  src_en,
  input  logic [NSRC-1:0]  src_hi,
  input  logic             glb_en,
  input  logic             act_lo,
  input  logic             act_hi,
  output logic             req,
  output logic [SRC_W-1:0] sel,
  output logic             sel_hi,
  output logic [NSRC-1:0]  grant
);

  logic [NSRC-1:0] elig, hi_c, lo_c;

  always_comb begin
    elig   = pend & src_en & {NSRC{glb_en}};
    hi_c   = elig & src_hi;
    lo_c   = elig & ~src_hi;
    sel_hi = |hi_c;
    grant  = sel_hi ? lowest_one(hi_c) : lowest_one(lo_c);
    sel    = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (grant[i]) sel = SRC_W'(i);
    end
    req = (|elig) && !act_hi && (!act_lo || sel_hi);
  end

endmodule

// File: rtl/irq_level_tracker.sv
module irq_level_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic take_hi,
  input  logic reti,
  output logic act_lo,
  output logic act_hi
);

  logic lo_d, hi_d;

  always_comb begin
    lo_d = act_lo;
    hi_d = act_hi;
    if (reti) begin
      if (act_hi) hi_d = 1'b0;
      else        lo_d = 1'b0;
    end
    if (take) begin
      if (take_hi) hi_d = 1'b1;
      else         lo_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_lo <= 1'b0;
      act_hi <= 1'b0;
    end else begin
      act_lo <= lo_d;
      act_hi <= hi_d;
    end
  end

  p_hi_fall_reti_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(act_hi) |-> $past(reti));
  p_lo_fall_reti_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(act_lo) |-> $past(reti) && !$past(act_hi));

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irq_vec_pkg::*;
#(
  parameter int              VEC_W    = 16,
  parameter logic [VEC_W-1:0] VEC_BASE = 16'h0003,
  parameter logic [VEC_W-1:0] VEC_STEP = 16'h0008
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic [NPAIR-1:0] ext_line,
  input  logic [NPAIR-1:0] ext_edge_mode,
  input  logic [NPAIR-1:0] tmr_ovf,
  input  logic             ser_rx,
  input  logic             ser_tx,
  input  logic             glb_en,
  input  logic [NSRC-1:0]  src_en,
  input  logic [NSRC-1:0]  src_hi,
  input  logic             ack,
  input  logic             reti,
  output logic             irq_req,
  output logic [VEC_W-1:0] irq_vec,
  output logic [SRC_W-1:0] irq_src,
  output logic             act_lo,
  output logic             act_hi
);

  logic [1:0]       rst_sync;
  logic             rst_n;
  logic [NSRC-1:0]  pend, grant;
  logic [NPAIR-1:0] clr_ext, clr_tmr;
  logic [SRC_W-1:0] sel;
  logic             sel_hi, req, take;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) rst_sync <= 2'b00;
    else         rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n = rst_sync[1];

  assign take = ack & req;

  generate
    for (genvar k = 0; k < NPAIR; k++) begin : g_clr
      assign clr_ext[k] = take & grant[2*k];
      assign clr_tmr[k] = take & grant[2*k+1];
    end
  endgenerate

  irq_flag_bank u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .ext_line (ext_line),
    .ext_edge (ext_edge_mode),
    .tmr_set  (tmr_ovf),
    .clr_ext  (clr_ext),
    .clr_tmr  (clr_tmr),
    .ser_rx   (ser_rx),
    .ser_tx   (ser_tx),
    .pend     (pend)
  );

  irq_arbiter u_arb (
    .pend   (pend),
    .src_en (src_en),
    .src_hi (src_hi),
    .glb_en (glb_en),
    .act_lo (act_lo),
    .act_hi (act_hi),
    .req    (req),
    .sel    (sel),
    .sel_hi (sel_hi),
    .grant  (grant)
  );

  irq_level_tracker u_lvl (
    .clk     (clk),
    .rst_n   (rst_n),
    .take    (take),
    .take_hi (sel_hi),
    .reti    (reti),
    .act_lo  (act_lo),
    .act_hi  (act_hi)
  );

  assign irq_req = req;
  assign irq_src = req ? sel : '0;
  assign irq_vec = req ? (VEC_BASE + VEC_STEP * VEC_W'(sel)) : '0;

  p_req_enabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> glb_en && ((src_en & grant) != '0));
  p_hi_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    act_hi |-> !irq_req);
  p_preempt_hi_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && act_lo) |-> sel_hi);
  p_grant_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  p_take_sets_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !reti) |=> (act_lo || act_hi));

endmodule

// File: tb/sim_irq_vector_ctrl.sv
`timescale 1ns/100ps
module sim_irq_vector_ctrl;

  logic        clk = 1'b0;
  logic        arst_n;
  logic [1:0]  ext_line, ext_edge_mode, tmr_ovf;
  logic        ser_rx, ser_tx, glb_en, ack, reti;
  logic [4:0]  src_en, src_hi;
  logic        irq_req, act_lo, act_hi;
  logic [15:0] irq_vec;
  logic [2:0]  irq_src;

  int errors = 0;
  int checks = 0;
  bit live = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_vector_ctrl u0 (
    .clk(clk), .arst_n(arst_n), .ext_line(ext_line), .ext_edge_mode(ext_edge_mode),
    .tmr_ovf(tmr_ovf), .ser_rx(ser_rx), .ser_tx(ser_tx), .glb_en(glb_en),
    .src_en(src_en), .src_hi(src_hi), .ack(ack), .reti(reti), .irq_req(irq_req),
    .irq_vec(irq_vec), .irq_src(irq_src), .act_lo(act_lo), .act_hi(act_hi)
  );

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", tag, got, exp, $time);
    end
  endtask

  // behavioural reference model
  bit m_ext[2], m_prev[2], m_tmr[2];
  bit m_lo, m_hi;

  task automatic m_eval(output bit req, output int idx, output bit ishi);
    bit pend[5];
    pend[0] = m_ext[0]; pend[1] = m_tmr[0];
    pend[2] = m_ext[1]; pend[3] = m_tmr[1];
    pend[4] = ser_rx || ser_tx;
    idx = -1; ishi = 0;
    for (int lvl = 1; lvl >= 0; lvl--)
      for (int i = 0; i < 5; i++)
        if (idx < 0 && pend[i] && glb_en && src_en[i] && (int'(src_hi[i]) == lvl)) begin
          idx = i; ishi = (lvl == 1);
        end
    req = (idx >= 0) && !m_hi && (!m_lo || ishi);
  endtask

  always @(posedge clk) begin
    bit r, h; int i; bit take;
    if (!live) begin
      for (int k = 0; k < 2; k++) begin m_ext[k] = 0; m_prev[k] = 0; m_tmr[k] = 0; end
      m_lo = 0; m_hi = 0;
    end else begin
      m_eval(r, i, h);
      take = ack && r;
      for (int k = 0; k < 2; k++) begin
        if (ext_edge_mode[k]) begin
          if (ext_line[k] && !m_prev[k]) m_ext[k] = 1;
          else if (take && i == 2*k) m_ext[k] = 0;
        end else m_ext[k] = ext_line[k];
        m_prev[k] = ext_line[k];
        if (tmr_ovf[k]) m_tmr[k] = 1;
        else if (take && i == 2*k+1) m_tmr[k] = 0;
      end
      if (reti) begin
        if (m_hi) m_hi = 0; else m_lo = 0;
      end
      if (take) begin
        if (h) m_hi = 1; else m_lo = 1;
      end
    end
  end

  always @(negedge clk) begin
    bit r, h; int i;
    if (live && !done) begin
      m_eval(r, i, h);
      chk("R6 model irq_req", irq_req, r);
      chk("R4 model irq_vec", irq_vec, r ? 3 + 8*i : 0);
      chk("R3 model irq_src", irq_src, r ? i : 0);
      chk("R7 model act_lo", act_lo, m_lo);
      chk("R7 model act_hi", act_hi, m_hi);
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic serve();
    ack = 1; tick(); ack = 0;
    reti = 1; tick(); reti = 0; settle();
  endtask

  task automatic expect_req(input string tag, input int vec);
    chk({tag, " req"}, irq_req, vec != 0);
    chk({tag, " vec"}, irq_vec, vec);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got hung expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    arst_n = 0; ext_line = 0; ext_edge_mode = 0; tmr_ovf = 0;
    ser_rx = 0; ser_tx = 0; glb_en = 0; ack = 0; reti = 0;
    src_en = 5'h1F; src_hi = 0;
    repeat (3) tick();
    arst_n = 1;
    repeat (4) tick();
    settle();
    // R1 reset state
    chk("R1 irq_req", irq_req, 0);
    chk("R1 act_lo", act_lo, 0);
    chk("R1 act_hi", act_hi, 0);
    glb_en = 1; settle();
    chk("R1 no flag pending", irq_req, 0);
    glb_en = 0;
    live = 1;

    // R2 / R8: timer 0 gated by enables
    tmr_ovf = 2'b01; tick(); tmr_ovf = 0; settle();
    chk("R2 glb_en off", irq_req, 0);
    glb_en = 1; src_en = 5'h1D; settle();
    chk("R2 src_en off", irq_req, 0);
    src_en = 5'h1F; settle();
    expect_req("R8 timer0", 16'h000B);
    chk("R3 src timer0", irq_src, 1);
    ack = 1; tick(); ack = 0; settle();
    chk("R6 act_lo after ack", act_lo, 1);
    reti = 1; tick(); reti = 0; settle();
    chk("R7 act_lo after reti", act_lo, 0);
    chk("R8 flag cleared", irq_req, 0);

    // R3 / R4 / R10 order within one level
    ext_edge_mode = 2'b10; ext_line = 2'b10; tmr_ovf = 2'b10; ser_rx = 1;
    tick(); tmr_ovf = 0; ext_line = 0; tick(); settle();
    expect_req("R3 ext1 first", 16'h0013);
    serve();
    expect_req("R9 ext1 cleared, timer1 next", 16'h001B);
    serve();
    expect_req("R4 serial vector", 16'h0023);
    serve();
    expect_req("R10 serial kept", 16'h0023);
    ser_rx = 0; ser_tx = 1; settle();
    expect_req("R10 tx alone", 16'h0023);
    ser_tx = 0; settle();
    chk("R10 both clear", irq_req, 0);

    // R5 / R6 / R7 nesting
    ext_edge_mode = 0; ext_line = 2'b01; ser_tx = 1; src_hi = 5'b10000;
    tick(); settle();
    expect_req("R5 high wins", 16'h0023);
    ack = 1; tick(); ack = 0; settle();
    chk("R6 act_hi", act_hi, 1);
    chk("R6 high blocks all", irq_req, 0);
    reti = 1; tick(); reti = 0; settle();
    chk("R7 act_hi cleared", act_hi, 0);
    src_hi = 0; settle();
    expect_req("R3 ext0 first", 16'h0003);
    ack = 1; tick(); ack = 0; settle();
    chk("R6 equal level blocked", irq_req, 0);
    src_hi = 5'b10000; settle();
    expect_req("R6 preempt", 16'h0023);
    ack = 1; tick(); ack = 0; settle();
    chk("R6 nested hi", act_hi, 1);
    chk("R6 nested lo", act_lo, 1);
    reti = 1; tick(); reti = 0; settle();
    chk("R7 hi first", act_hi, 0);
    chk("R7 lo kept", act_lo, 1);
    src_hi = 0; ser_tx = 0;
    reti = 1; tick(); reti = 0; settle();
    chk("R7 lo cleared", act_lo, 0);
    expect_req("R9 level not cleared", 16'h0003);
    ext_line = 0; tick(); settle();
    chk("R9 level follows line", irq_req, 0);

    // R9 edge latch and R2 withdraw
    ext_edge_mode = 2'b01; ext_line = 2'b01; tick(); ext_line = 0; tick(); settle();
    expect_req("R9 edge latched", 16'h0003);
    glb_en = 0; settle();
    chk("R2 withdrawn", irq_req, 0);
    glb_en = 1; settle();
    expect_req("R2 restored", 16'h0003);
    serve();
    chk("R9 edge cleared on ack", irq_req, 0);

    // R8 new pulse wins over clear
    tmr_ovf = 2'b01; tick(); tmr_ovf = 0; settle();
    expect_req("R8 timer0 again", 16'h000B);
    ack = 1; tmr_ovf = 2'b01; tick(); ack = 0; tmr_ovf = 0; settle();
    chk("R8 act_lo", act_lo, 1);
    reti = 1; tick(); reti = 0; settle();
    expect_req("R8 set wins", 16'h000B);
    serve();
    chk("R8 cleared", irq_req, 0);

    tick();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule